// File: doc/BRIEF.md
# Secondary System-Error Reporter

This block sits on the secondary side of a PCIe-to-PCI bridge and watches the active-low system-error line driven by devices on the conventional PCI bus. It samples the line on the bridge clock. A high-to-low transition counts as one error event. Each event is recorded in two independent status bits: one in the legacy bridge status view and one in the native uncorrectable-error status view. A first-error pointer is updated only when no earlier error of this class is still pending. The block then decides whether an upstream error message must be raised, and whether it is fatal or non-fatal.

A message is raised only when the error is unmasked and at least one reporting path is open. The legacy path is a single system-error enable. The native path uses the fatal or non-fatal reporting enable that matches the severity bit. The message request stays asserted until the upstream side accepts it, so when the link is ready it lasts one cycle. No transaction header is captured for this error class. Software reaches the registers through a simple write port with address and data, and reads them back through a combinational read port.

Top module: `serr_reporter`

## Requirements
- R1: An event is a high-to-low transition of `serr_ni` sampled on the clock. A low level lasting several cycles produces exactly one event and at most one message.
- R2: The cycle after an event, bit 0 of address 0 (legacy signalled-system-error status) reads 1.
- R3: The cycle after an event, bit 0 of address 1 (uncorrectable system-error status) reads 1, whatever the mask bit holds.
- R4: Writing 1 to bit 0 of address 0 or address 1 clears that status bit. Writing 0 leaves it unchanged.
- R5: A message is requested only if the mask bit (address 2, bit 0) is 0. One of these must also hold: the system-error enable (address 5, bit 0) is 1, or the severity-matched enable (address 5, bit 1 for fatal, bit 2 for non-fatal) is 1.
- R6: The message type `msg_fatal_o` equals the severity bit (address 3, bit 0) at the time of the event: 1 means fatal, 0 means non-fatal.
- R7: The first-error pointer (address 4, bits PTR_W-1:0) is loaded with `PTR_CODE` on an event only if the uncorrectable status bit was 0 before the event. Otherwise it keeps its value. Software may write it.
- R8: `msg_req_o` rises the cycle after a qualifying event. It stays high with a stable type while `msg_rdy_i` is 0. It falls the cycle after a cycle in which it is high and `msg_rdy_i` is 1.
- R9: After reset, every register reads 0 and `msg_req_o` is 0.
- R10: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serr_ni | input | 1 | Secondary system-error line, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for writes and reads |
| reg_wdata_i | input | PTR_W | Write data |
| reg_rdata_o | output | PTR_W | Read data for `reg_addr_i` |
| msg_req_o | output | 1 | Upstream error message request |
| msg_fatal_o | output | 1 | Message type, 1 fatal, 0 non-fatal |
| msg_rdy_i | input | 1 | Upstream accepts the request |

## Verification
The bench uses the defaults PTR_W = 5 and PTR_CODE = 9. This keeps the pointer code distinct from both zero and any value written by the bench, so an update and a non-update look different. It sweeps all 32 combinations of mask, severity and the three enables with the link ready, which covers every gating and type outcome. It then runs directed cases: a held-low assertion, a stalled link, a clear that collides with an event, and a pointer that is already occupied.

// File: rtl/serr_pkg.sv
package serr_pkg;
  typedef enum logic [2:0] {
    ADDR_LEG_STAT = 3'd0,
    ADDR_UNC_STAT = 3'd1,
    ADDR_MASK     = 3'd2,
    ADDR_SEV      = 3'd3,
    ADDR_PTR      = 3'd4,
    ADDR_CTRL     = 3'd5
  } serr_addr_e;

  localparam int unsigned CtrlSerrEn  = 0;
  localparam int unsigned CtrlFatalEn = 1;
  localparam int unsigned CtrlNfatEn  = 2;
endpackage

// File: rtl/serr_edge.sv
module serr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic serr_ni,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= serr_ni;
  end

  assign evt_o = prev_q & ~serr_ni;

  assert_one_evt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/serr_regs.sv
module serr_regs import serr_pkg::*; #(
  parameter int unsigned PTR_W = 5,
  parameter logic [PTR_W-1:0] PTR_CODE = PTR_W'(9)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [PTR_W-1:0] wdata_i,
  input  logic             evt_i,
  output logic [PTR_W-1:0] rdata_o,
  output logic             mask_o,
  output logic             sev_o,
  output logic             serr_en_o,
  output logic             fatal_en_o,
  output logic             nfat_en_o
);
  logic             leg_q, unc_q, mask_q, sev_q;
  logic [2:0]       ctrl_q;
  logic [PTR_W-1:0] ptr_q;
  logic             wr_leg, wr_unc;

  assign wr_leg = we_i && (addr_i == ADDR_LEG_STAT) && wdata_i[0];
  assign wr_unc = we_i && (addr_i == ADDR_UNC_STAT) && wdata_i[0];

  // status: set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q <= 1'b0;
      unc_q <= 1'b0;
    end else begin
      if (evt_i)       leg_q <= 1'b1;
      else if (wr_leg) leg_q <= 1'b0;
      if (evt_i)       unc_q <= 1'b1;
      else if (wr_unc) unc_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      sev_q  <= 1'b0;
      ctrl_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_MASK) mask_q <= wdata_i[0];
      if (addr_i == ADDR_SEV)  sev_q  <= wdata_i[0];
      if (addr_i == ADDR_CTRL) ctrl_q <= wdata_i[2:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ptr_q <= '0;
    else if (evt_i && !unc_q)         ptr_q <= PTR_CODE;
    else if (we_i && addr_i == ADDR_PTR) ptr_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_LEG_STAT: rdata_o[0]   = leg_q;
      ADDR_UNC_STAT: rdata_o[0]   = unc_q;
      ADDR_MASK:     rdata_o[0]   = mask_q;
      ADDR_SEV:      rdata_o[0]   = sev_q;
      ADDR_PTR:      rdata_o      = ptr_q;
      ADDR_CTRL:     rdata_o[2:0] = ctrl_q;
      default:       rdata_o      = '0;
    endcase
  end

  assign mask_o     = mask_q;
  assign sev_o      = sev_q;
  assign serr_en_o  = ctrl_q[CtrlSerrEn];
  assign fatal_en_o = ctrl_q[CtrlFatalEn];
  assign nfat_en_o  = ctrl_q[CtrlNfatEn];

  assert_leg_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> leg_q);
  assert_unc_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> unc_q);
  assert_ptr_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && unc_q && !(we_i && addr_i == ADDR_PTR)) |=> $stable(ptr_q));
endmodule

// File: rtl/serr_msg.sv
module serr_msg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic send_i,
  input  logic fatal_i,
  input  logic rdy_i,
  output logic req_o,
  output logic fatal_o
);
  logic pend_q, typ_q, load;

  // one outstanding request; a new one loads when the slot frees this cycle
  assign load = evt_i && send_i && (!pend_q || rdy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      typ_q  <= 1'b0;
    end else if (load) begin
      pend_q <= 1'b1;
      typ_q  <= fatal_i;
    end else if (pend_q && rdy_i) begin
      pend_q <= 1'b0;
    end
  end

  assign req_o   = pend_q;
  assign fatal_o = typ_q;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rdy_i) |=> (req_o && $stable(fatal_o)));
  assert_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && rdy_i && !evt_i) |=> !req_o);
  assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !send_i && !req_o) |=> !req_o);
  assert_type_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && send_i && !req_o) |=> (req_o && fatal_o == $past(fatal_i)));
endmodule

// File: rtl/serr_reporter.sv
module serr_reporter #(
  parameter int unsigned PTR_W = 5,
  parameter logic [PTR_W-1:0] PTR_CODE = PTR_W'(9)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             serr_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [PTR_W-1:0] reg_wdata_i,
  output logic [PTR_W-1:0] reg_rdata_o,
  output logic             msg_req_o,
  output logic             msg_fatal_o,
  input  logic             msg_rdy_i
);
  logic evt, mask, sev, serr_en, fatal_en, nfat_en, send;

  serr_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .serr_ni(serr_ni),
    .evt_o  (evt)
  );

  serr_regs #(.PTR_W(PTR_W), .PTR_CODE(PTR_CODE)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .evt_i     (evt),
    .rdata_o   (reg_rdata_o),
    .mask_o    (mask),
    .sev_o     (sev),
    .serr_en_o (serr_en),
    .fatal_en_o(fatal_en),
    .nfat_en_o (nfat_en)
  );

  // unmasked, and legacy enable or severity-matched native enable
  assign send = !mask && (serr_en || (sev ? fatal_en : nfat_en));

  serr_msg i_msg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .send_i (send),
    .fatal_i(sev),
    .rdy_i  (msg_rdy_i),
    .req_o  (msg_req_o),
    .fatal_o(msg_fatal_o)
  );
endmodule

// File: tb/test_serr_reporter.sv
`timescale 1ns/1ps
module test_serr_reporter;
  localparam int unsigned PW = 5;
  localparam logic [PW-1:0] CODE = 5'd9;

  logic          clk = 1'b0, rst_n = 1'b0, serr_n = 1'b1;
  logic          we = 1'b0, rdy = 1'b1;
  logic [2:0]    addr = 3'd0;
  logic [PW-1:0] wdata = '0, rdata;
  logic          req, fatal;
  int            checks = 0, errors = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  serr_reporter #(.PTR_W(PW), .PTR_CODE(CODE)) i_serr_reporter (
    .clk_i(clk), .rst_ni(rst_n), .serr_ni(serr_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .msg_req_o(req), .msg_fatal_o(fatal),
    .msg_rdy_i(rdy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [PW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); chk("R9 reg", v, 0); end
    chk("R9 req", int'(req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5/R6/R2/R3/R7 sweep over all gating configs, link ready
    for (int c = 0; c < 32; c++) begin
      bit mk, sv, se, fe, ne, exp;
      mk = c[0]; sv = c[1]; se = c[2]; fe = c[3]; ne = c[4];
      exp = !mk && (se || (sv ? fe : ne));
      wr(3'd2, PW'(mk)); wr(3'd3, PW'(sv));
      wr(3'd5, PW'({ne, fe, se}));
      wr(3'd0, 5'd1); wr(3'd1, 5'd1); wr(3'd4, 5'd0);
      serr_n = 1'b0;
      @(negedge clk);
      chk("R5 req gate", int'(req), int'(exp));
      if (exp) chk("R6 type", int'(fatal), int'(sv));
      rd(3'd0, v); chk("R2 legacy status", v, 1);
      rd(3'd1, v); chk("R3 unc status", v, 1);
      rd(3'd4, v); chk("R7 ptr load", v, int'(CODE));
      serr_n = 1'b1;
      @(negedge clk);
      chk("R8 single cycle", int'(req), 0);
    end

    // R4 write-one-to-clear, zero write ignored
    wr(3'd0, 5'd0); rd(3'd0, v); chk("R4 leg zero", v, 1);
    wr(3'd1, 5'd0); rd(3'd1, v); chk("R4 unc zero", v, 1);
    wr(3'd0, 5'd1); rd(3'd0, v); chk("R4 leg clr", v, 0);
    wr(3'd1, 5'd1); rd(3'd1, v); chk("R4 unc clr", v, 0);

    // R1 held low: one message only
    wr(3'd2, 5'd0); wr(3'd3, 5'd1); wr(3'd5, 5'd1);
    begin
      int pulses = 0;
      serr_n = 1'b0;
      for (int k = 0; k < 6; k++) begin @(negedge clk); if (req) pulses++; end
      serr_n = 1'b1;
      chk("R1 one event", pulses, 1);
    end
    @(negedge clk);

    // R7 pointer kept when status already set
    wr(3'd4, 5'd3);
    serr_n = 1'b0; @(negedge clk); serr_n = 1'b1;
    rd(3'd4, v); chk("R7 ptr keep", v, 3);
    @(negedge clk);

    // R8 stall: held with stable type until ready
    wr(3'd1, 5'd1);
    rdy = 1'b0;
    serr_n = 1'b0; @(negedge clk); serr_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R8 held", int'(req), 1);
      chk("R8 type stable", int'(fatal), 1);
      @(negedge clk);
    end
    rdy = 1'b1;
    @(negedge clk);
    chk("R8 drop", int'(req), 0);

    // R10 event collides with clear
    wr(3'd0, 5'd1);
    @(negedge clk);
    serr_n = 1'b0; we = 1'b1; addr = 3'd1; wdata = 5'd1;
    @(negedge clk);
    we = 1'b0; serr_n = 1'b1;
    rd(3'd1, v); chk("R10 set wins", v, 1);
    rd(3'd0, v); chk("R10 leg set", v, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule